// File: doc/BRIEF.md
# Packet Timestamp Capture Logger

This block stamps packet events with hardware time and keeps the stamps in two on-chip logs, one for the receive side and one for the transmit side. A free-running 64-bit counter advances once per core clock. When the receive or transmit path signals that a packet has finished, the block pairs the current time with a 16-bit packet identifier. Header-parsing logic upstream has already pulled that identifier out of a protocol field, such as an IP identification value or a probe sequence number. The pair is written as one 64-bit record into the log for that direction.

Each log is a circular memory whose depth need not be a power of two. When a log is full, new records replace the oldest ones. A write pointer and a saturating entry count tell a readout controller where the newest record sits and how many records are valid. The readout controller fetches records through a registered read port for each direction. Logging never feeds back into the packet path: the event inputs are only sampled, and nothing is ever asked of the source.

Top module: `pkt_stamp_logger`

## Requirements
- R1: `curTime` is 0 while reset is high and grows by exactly 1 on every clock edge after reset is released. The clear input has no effect on it.
- R2: A record holds the packet identifier in bits [63:48]. Bits [47:0] hold the low 48 bits of `curTime` as sampled on the clock edge where the event strobe is seen high.
- R3: A record is written into its log on the edge after the strobe edge, at the address shown on that direction's write pointer. Pointer and count move on that same later edge, so they are visible two sampling points after the strobe is driven.
- R4: The write pointer steps from DEPTH-1 back to 0. Once the log has wrapped, each new record overwrites the oldest one.
- R5: The entry count increases by one per record and saturates at DEPTH.
- R6: The receive and transmit logs are independent. Events on both sides in the same cycle are both recorded, each in its own log.
- R7: A synchronous clear sets both write pointers and both counts to 0. Memory contents and `curTime` are left unchanged.
- R8: Read data is registered: `rxRdData`/`txRdData` show the record at the address presented one clock edge earlier.
- R9: Strobes on consecutive cycles are all recorded, one record per strobe, in order.
- R10: While reset is high, both write pointers and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of pointers and counts |
| rxEvt | input | 1 | Receive packet completed |
| rxId | input | 16 | Identifier of the received packet |
| txEvt | input | 1 | Transmit packet completed |
| txId | input | 16 | Identifier of the transmitted packet |
| rxRdAddr | input | PTR_W | Receive log read address |
| rxRdData | output | 64 | Receive log read data |
| txRdAddr | input | PTR_W | Transmit log read address |
| txRdData | output | 64 | Transmit log read data |
| rxWrPtr | output | PTR_W | Next receive write address |
| rxCount | output | CNT_W | Valid receive records |
| txWrPtr | output | PTR_W | Next transmit write address |
| txCount | output | CNT_W | Valid transmit records |
| curTime | output | TIME_W | Free-running time counter |

## Verification
The logging function is driven by a stream of strobe patterns with the depth reduced to six:
- Receive alone, transmit alone and both sides together separate the two logs from each other.
- Idle gaps between events, and strobes on back-to-back cycles, show whether any record is lost or duplicated.
- Enough receive events to pass the depth show whether the pointer wraps, the oldest entry is overwritten and the count saturates.

A clear followed by a single event shows two things. First, that the clear keeps the stored contents and the time counter. Second, that the pointer and count lag the strobe by the intended latency.

// File: rtl/pkt_stamp_pkg.sv
package pkt_stamp_pkg;
  parameter int ID_W    = 16;
  parameter int STAMP_W = 48;
  parameter int REC_W   = ID_W + STAMP_W;
  parameter int NUM_DIR = 2;
  parameter int DIR_RX  = 0;
  parameter int DIR_TX  = 1;

  // Strobes from control to datapath, one bit per direction
  typedef struct packed {
    logic [NUM_DIR-1:0] capture;  // latch identifier and time now
    logic [NUM_DIR-1:0] commit;   // write latched record to memory
  } stampStrobes_t;
endpackage

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import pkt_stamp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DEPTH  = 1536,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic [NUM_DIR-1:0]              evt,
  output stampStrobes_t                   strobes,
  output logic [NUM_DIR-1:0][PTR_W-1:0]   wrPtr,
  output logic [NUM_DIR-1:0][CNT_W-1:0]   count,
  output logic [TIME_W-1:0]               timeNow
);
  localparam logic [PTR_W-1:0] LAST_ADDR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [NUM_DIR-1:0] pending;

  always_ff @(posedge clk) begin
    if (rst) timeNow <= '0;
    else     timeNow <= timeNow + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= evt;
  end

  always_comb begin
    strobes.capture = evt;
    strobes.commit  = pending & {NUM_DIR{~clr}};
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        wrPtr[d] <= '0;
        count[d] <= '0;
      end else if (pending[d]) begin
        wrPtr[d] <= (wrPtr[d] == LAST_ADDR) ? '0 : wrPtr[d] + 1'b1;
        if (count[d] != FULL_CNT) count[d] <= count[d] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stamp_datapath.sv
module stamp_datapath
  import pkt_stamp_pkg::*;
#(
  parameter int DEPTH = 1536,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                            clk,
  input  stampStrobes_t                   strobes,
  input  logic [STAMP_W-1:0]              timeLow,
  input  logic [NUM_DIR-1:0][ID_W-1:0]    pktId,
  input  logic [NUM_DIR-1:0][PTR_W-1:0]   wrAddr,
  input  logic [NUM_DIR-1:0][PTR_W-1:0]   rdAddr,
  output logic [NUM_DIR-1:0][REC_W-1:0]   rdData
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_log
    logic [REC_W-1:0] heldRec;
    logic [REC_W-1:0] logMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.capture[d]) heldRec <= {pktId[d], timeLow};
    end

    always_ff @(posedge clk) begin
      if (strobes.commit[d]) logMem[wrAddr[d]] <= heldRec;
      rdData[d] <= logMem[rdAddr[d]];
    end
  end
endmodule

// File: rtl/pkt_stamp_logger.sv
module pkt_stamp_logger
  import pkt_stamp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DEPTH  = 1536,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rxEvt,
  input  logic [ID_W-1:0]   rxId,
  input  logic              txEvt,
  input  logic [ID_W-1:0]   txId,
  input  logic [PTR_W-1:0]  rxRdAddr,
  output logic [REC_W-1:0]  rxRdData,
  input  logic [PTR_W-1:0]  txRdAddr,
  output logic [REC_W-1:0]  txRdData,
  output logic [PTR_W-1:0]  rxWrPtr,
  output logic [CNT_W-1:0]  rxCount,
  output logic [PTR_W-1:0]  txWrPtr,
  output logic [CNT_W-1:0]  txCount,
  output logic [TIME_W-1:0] curTime
);
  stampStrobes_t                 strobes;
  logic [NUM_DIR-1:0][PTR_W-1:0] wrPtr;
  logic [NUM_DIR-1:0][CNT_W-1:0] count;
  logic [NUM_DIR-1:0][REC_W-1:0] rdData;
  logic [NUM_DIR-1:0]            evt;
  logic [NUM_DIR-1:0][ID_W-1:0]  pktId;
  logic [NUM_DIR-1:0][PTR_W-1:0] rdAddr;

  assign evt[DIR_RX]    = rxEvt;
  assign evt[DIR_TX]    = txEvt;
  assign pktId[DIR_RX]  = rxId;
  assign pktId[DIR_TX]  = txId;
  assign rdAddr[DIR_RX] = rxRdAddr;
  assign rdAddr[DIR_TX] = txRdAddr;

  stamp_ctrl #(.TIME_W(TIME_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .evt(evt), .strobes(strobes),
    .wrPtr(wrPtr), .count(count), .timeNow(curTime)
  );

  stamp_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .strobes(strobes), .timeLow(curTime[STAMP_W-1:0]),
    .pktId(pktId), .wrAddr(wrPtr), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign rxRdData = rdData[DIR_RX];
  assign txRdData = rdData[DIR_TX];
  assign rxWrPtr  = wrPtr[DIR_RX];
  assign txWrPtr  = wrPtr[DIR_TX];
  assign rxCount  = count[DIR_RX];
  assign txCount  = count[DIR_TX];
endmodule

// File: rtl/pkt_stamp_checker.sv
module pkt_stamp_checker #(
  parameter int TIME_W = 64,
  parameter int DEPTH  = 1536,
  parameter int PTR_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              rxEvt,
  input logic              txEvt,
  input logic [PTR_W-1:0]  rxWrPtr,
  input logic [CNT_W-1:0]  rxCount,
  input logic [PTR_W-1:0]  txWrPtr,
  input logic [CNT_W-1:0]  txCount,
  input logic [TIME_W-1:0] curTime
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] stepCnt(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(DEPTH)) ? c : c + 1'b1;
  endfunction

  assert_time_step_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> curTime == $past(curTime) + 1'b1);

  assert_rx_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (rxEvt ##1 !clr) |=> rxWrPtr == stepPtr($past(rxWrPtr)));

  assert_tx_ptr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (txEvt ##1 !clr) |=> txWrPtr == stepPtr($past(txWrPtr)));

  assert_rx_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    (rxEvt ##1 !clr) |=> rxCount == stepCnt($past(rxCount)));

  assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (rst)
    rxCount <= CNT_W'(DEPTH) && txCount <= CNT_W'(DEPTH));

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (rst)
    rxWrPtr < PTR_W'(DEPTH) && txWrPtr < PTR_W'(DEPTH));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> rxWrPtr == '0 && txWrPtr == '0 && rxCount == '0 && txCount == '0);
endmodule

bind pkt_stamp_logger pkt_stamp_checker #(
  .TIME_W(TIME_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .rxEvt(rxEvt), .txEvt(txEvt),
  .rxWrPtr(rxWrPtr), .rxCount(rxCount), .txWrPtr(txWrPtr), .txCount(txCount),
  .curTime(curTime)
);

// File: tb/tb_pkt_stamp_logger.sv
module tb_pkt_stamp_logger;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 6;
  localparam int TIME_W = 64;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NVEC   = 10;

  typedef struct packed {
    logic        rx;
    logic        tx;
    logic [15:0] rxId;
    logic [15:0] txId;
  } vec_t;

  // rx: 8 events (wraps depth 6), tx: 4 events; includes gaps, pairs, back-to-back
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 16'hA001, 16'h0000},
    '{1'b1, 1'b1, 16'hA002, 16'hB001},
    '{1'b1, 1'b0, 16'hA003, 16'h0000},
    '{1'b0, 1'b0, 16'h0000, 16'h0000},
    '{1'b1, 1'b1, 16'hA004, 16'hB002},
    '{1'b1, 1'b0, 16'hA005, 16'h0000},
    '{1'b1, 1'b0, 16'hA006, 16'h0000},
    '{1'b0, 1'b1, 16'h0000, 16'hB003},
    '{1'b1, 1'b1, 16'hA007, 16'hB004},
    '{1'b1, 1'b0, 16'hA008, 16'h0000}
  };

  logic              clk = 1'b0;
  logic              rst, clr, rxEvt, txEvt;
  logic [15:0]       rxId, txId;
  logic [PTR_W-1:0]  rxRdAddr, txRdAddr, rxWrPtr, txWrPtr;
  logic [63:0]       rxRdData, txRdData;
  logic [CNT_W-1:0]  rxCount, txCount;
  logic [TIME_W-1:0] curTime;

  int nChecks = 0;
  int nFails  = 0;

  logic [63:0] mRx [DEPTH];
  logic [63:0] mTx [DEPTH];
  int pRx = 0, cRx = 0, pTx = 0, cTx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_stamp_logger #(.TIME_W(TIME_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .clr(clr),
    .rxEvt(rxEvt), .rxId(rxId), .txEvt(txEvt), .txId(txId),
    .rxRdAddr(rxRdAddr), .rxRdData(rxRdData),
    .txRdAddr(txRdAddr), .txRdData(txRdData),
    .rxWrPtr(rxWrPtr), .rxCount(rxCount),
    .txWrPtr(txWrPtr), .txCount(txCount),
    .curTime(curTime)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readRx(input int addr, input logic [63:0] exp, input string req);
    @(negedge clk);
    rxRdAddr = PTR_W'(addr);
    @(negedge clk);
    check(req, rxRdData, exp);
  endtask

  task automatic readTx(input int addr, input logic [63:0] exp, input string req);
    @(negedge clk);
    txRdAddr = PTR_W'(addr);
    @(negedge clk);
    check(req, txRdData, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [63:0] t;
    logic [63:0] exp;
    rst = 1'b1; clr = 1'b0; rxEvt = 1'b0; txEvt = 1'b0;
    rxId = '0; txId = '0; rxRdAddr = '0; txRdAddr = '0;
    repeat (3) @(negedge clk);
    check("R10 rxWrPtr", 64'(rxWrPtr), 64'd0);
    check("R10 rxCount", 64'(rxCount), 64'd0);
    check("R10 txWrPtr", 64'(txWrPtr), 64'd0);
    check("R10 txCount", 64'(txCount), 64'd0);
    check("R1 time in reset", curTime, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first tick", curTime, 64'd1);
    t = curTime;
    @(negedge clk);
    check("R1 step", curTime, t + 64'd1);

    // Vector stream, one entry per cycle (R9 back-to-back, R6 simultaneous)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      rxEvt = VECS[i].rx; txEvt = VECS[i].tx;
      rxId  = VECS[i].rxId; txId = VECS[i].txId;
      t = curTime;
      if (VECS[i].rx) begin
        mRx[pRx] = {VECS[i].rxId, t[47:0]};
        pRx = (pRx == DEPTH - 1) ? 0 : pRx + 1;
        if (cRx < DEPTH) cRx++;
      end
      if (VECS[i].tx) begin
        mTx[pTx] = {VECS[i].txId, t[47:0]};
        pTx = (pTx == DEPTH - 1) ? 0 : pTx + 1;
        if (cTx < DEPTH) cTx++;
      end
    end
    @(negedge clk);
    rxEvt = 1'b0; txEvt = 1'b0;
    @(negedge clk);
    check("R4 rx pointer wrapped", 64'(rxWrPtr), 64'(pRx));
    check("R5 rx count saturated", 64'(rxCount), 64'(cRx));
    check("R6 tx pointer", 64'(txWrPtr), 64'(pTx));
    check("R6 tx count", 64'(txCount), 64'(cTx));
    for (int k = 0; k < DEPTH; k++) readRx(k, mRx[k], "R2 R4 R9 R8 rx record");
    for (int k = 0; k < cTx; k++)   readTx(k, mTx[k], "R2 R6 R8 tx record");

    // Clear: pointers and counts only (R7)
    @(negedge clk);
    clr = 1'b1;
    t = curTime;
    @(negedge clk);
    clr = 1'b0;
    check("R7 time unaffected by clear", curTime, t + 64'd1);
    check("R7 rxWrPtr cleared", 64'(rxWrPtr), 64'd0);
    check("R7 rxCount cleared", 64'(rxCount), 64'd0);
    check("R7 txWrPtr cleared", 64'(txWrPtr), 64'd0);
    check("R7 txCount cleared", 64'(txCount), 64'd0);
    readRx(3, mRx[3], "R7 contents kept");

    // Single event after clear: latency of pointer and count (R3)
    @(negedge clk);
    rxEvt = 1'b1; rxId = 16'hC001;
    t = curTime;
    exp = {16'hC001, t[47:0]};
    @(negedge clk);
    rxEvt = 1'b0;
    check("R3 count not yet moved", 64'(rxCount), 64'd0);
    @(negedge clk);
    check("R3 count after write", 64'(rxCount), 64'd1);
    check("R3 pointer after write", 64'(rxWrPtr), 64'd1);
    check("R6 tx untouched", 64'(txCount), 64'd0);
    readRx(0, exp, "R3 R2 record at pointer");
    readRx(1, mRx[1], "R7 older entry kept");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule